// File: doc/BRIEF.md
# Pre-Adder Multiply-Accumulate Slice with Partitionable Adder

This block is a three-stage pipelined arithmetic slice. It can multiply-accumulate, add two wide operands, run lane-split add, subtract and accumulate operations, or apply a bitwise logic function. A 25-bit pre-adder forms one multiplier operand from two inputs, which suits symmetric filter taps where two samples share a coefficient. The sum is multiplied by an 18-bit coefficient in two's complement. The product is then folded into a 48-bit result register.

Every cycle the slice accepts one operation, chosen by an opcode. The 48-bit adder can run as one 48-bit lane, two 24-bit lanes or four 12-bit lanes. No carry crosses a lane boundary, and each lane reports its own carry. A clear control replaces the accumulator feedback with zero, so a fresh accumulation starts on the same cycle it is requested. With an increment of one, the accumulate operation turns the result register into an up/down counter.

Top module: `mac_slice`

## Requirements
- R1: While `rst_n` is low, `p_o` and `cy_o` read zero. After reset is released, they stay zero until an operation changes them.
- R2: An operation is presented before clock edge E. Its result appears on `p_o`/`cy_o` after edge E+2 and not earlier. A new operation can be issued every cycle, and operations take effect in issue order.
- R3: With `op_i`=0 (multiply-accumulate), the result is F + M, or F − M when `sub_i`=1. F is the previous result, or zero when `clr_i`=1. M is the signed product of the pre-adder sum and `b_i`, sign-extended to 48 bits. The adder always works as one 48-bit lane for this operation.
- R4: The pre-adder sum `a_i + d_i` wraps to 25 bits (two's complement) before it is multiplied.
- R5: With `op_i`=1 (wide add), the result is `x_i + y_i`, or `x_i − y_i` when `sub_i`=1. The previous result plays no part, and `clr_i` has no effect.
- R6: For `op_i`=1 and `op_i`=2, `simd_i` selects the lane split: 0 gives one 48-bit lane, 1 gives two 24-bit lanes, and 2 or 3 gives four 12-bit lanes. No carry or borrow passes from one lane to the next.
- R7: `cy_o[i]` reports the carry out of bits 12i+11..12i, but only when those bits form the top of a lane; all other bits of `cy_o` are zero. In a subtraction, the carry is 1 when there is no borrow.
- R8: With `op_i`=2 (accumulate), the result is F + `y_i`, or F − `y_i` when `sub_i`=1, per lane. F is as in R3. An increment of 1 therefore counts up or down, and a hold is `y_i`=0, `sub_i`=0, `clr_i`=0.
- R9: `clr_i`=1 makes F zero, so an accumulation restarts with no extra cycle.
- R10: With `op_i`=3 (logic), the result is a function of `x_i` and `y_i` picked by `lfn_i`. The codes are 0 AND, 1 OR, 2 XOR, 3 NAND, 4 NOR, 5 XNOR, 6 x AND NOT y, 7 x OR NOT y, 8 NOT x, 9 pass x. Codes 10 to 15 give zero, and `cy_o` is zero for every logic operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | Operation: 0 multiply-acc, 1 wide add, 2 accumulate, 3 logic |
| simd_i | input | 2 | Lane split for add and accumulate |
| sub_i | input | 1 | Subtract instead of add |
| clr_i | input | 1 | Zero the accumulator feedback |
| lfn_i | input | 4 | Logic function code |
| a_i | input | 25 | Pre-adder operand |
| d_i | input | 25 | Pre-adder operand |
| b_i | input | 18 | Multiplier coefficient |
| x_i | input | 48 | First wide operand |
| y_i | input | 48 | Second wide operand |
| p_o | output | 48 | Result register |
| cy_o | output | 4 | Per-lane carry out |

## Verification
The assertions assume that every input carries a defined value on every clock edge, because each cycle issues an operation. They also assume that a hold is expressed as an accumulate of zero with clear and subtract low. The bench follows this: it keeps all inputs driven, and between operations it drives exactly that hold word. The result register therefore changes only through the operations that are being checked.

// File: rtl/mac_slice.sv
module mac_slice #(
  parameter int AW    = 25,
  parameter int BW    = 18,
  parameter int PW    = 48,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       op_i,
  input  logic [1:0]       simd_i,
  input  logic             sub_i,
  input  logic             clr_i,
  input  logic [3:0]       lfn_i,
  input  logic [AW-1:0]    a_i,
  input  logic [AW-1:0]    d_i,
  input  logic [BW-1:0]    b_i,
  input  logic [PW-1:0]    x_i,
  input  logic [PW-1:0]    y_i,
  output logic [PW-1:0]    p_o,
  output logic [LANES-1:0] cy_o
);
  localparam int LW   = PW / LANES;
  localparam int MW   = AW + BW;
  localparam int HALF = LANES / 2;
  localparam logic [1:0] OP_MAC = 2'd0, OP_ADD = 2'd1, OP_ACC = 2'd2, OP_LOG = 2'd3;

  logic [1:0]    op1, simd1, op2, simd2;
  logic          sub1, clr1, sub2, clr2;
  logic [3:0]    lfn1, lfn2;
  logic [AW-1:0] a1, d1, pre;
  logic [BW-1:0] b1;
  logic [PW-1:0] x1, y1, x2, y2, m2;
  logic signed [MW-1:0] prod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {op1, simd1, sub1, clr1, lfn1, a1, d1, b1, x1, y1} <= '0;
      {op2, simd2, sub2, clr2, lfn2, m2, x2, y2} <= '0;
    end else begin
      {op1, simd1, sub1, clr1, lfn1} <= {op_i, simd_i, sub_i, clr_i, lfn_i};
      {a1, d1, b1, x1, y1} <= {a_i, d_i, b_i, x_i, y_i};
      {op2, simd2, sub2, clr2, lfn2} <= {op1, simd1, sub1, clr1, lfn1};
      m2 <= {{(PW-MW){prod[MW-1]}}, prod};
      x2 <= x1;
      y2 <= y1;
    end
  end

  assign pre  = a1 + d1;
  assign prod = $signed(pre) * $signed(b1);

  logic [1:0]    mode;
  logic [PW-1:0] fb, u, v, sum, lres;
  logic [LANES-1:0] lc, lcy;

  assign mode = (op2 == OP_MAC) ? 2'd0 : simd2[1] ? 2'd2 : simd2[0] ? 2'd1 : 2'd0;
  assign fb   = clr2 ? '0 : p_o;
  assign u    = (op2 == OP_ADD) ? x2 : fb;
  assign v    = ((op2 == OP_MAC) ? m2 : y2) ^ {PW{sub2}};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic start, last, cin;
    logic [LW:0] s;
    assign start = (i % LANES == 0) || (mode == 2'd2) || (mode == 2'd1 && (i % HALF) == 0);
    assign last  = ((i + 1) % LANES == 0) || (mode == 2'd2) || (mode == 2'd1 && ((i + 1) % HALF) == 0);
    if (i == 0) begin : g_first
      assign cin = sub2;
    end else begin : g_rest
      assign cin = start ? sub2 : lc[i-1];
    end
    assign s = {1'b0, u[i*LW +: LW]} + {1'b0, v[i*LW +: LW]} + {{LW{1'b0}}, cin};
    assign sum[i*LW +: LW] = s[LW-1:0];
    assign lc[i]  = s[LW];
    assign lcy[i] = last & s[LW];
  end

  always_comb begin
    case (lfn2)
      4'd0:    lres = x2 & y2;
      4'd1:    lres = x2 | y2;
      4'd2:    lres = x2 ^ y2;
      4'd3:    lres = ~(x2 & y2);
      4'd4:    lres = ~(x2 | y2);
      4'd5:    lres = ~(x2 ^ y2);
      4'd6:    lres = x2 & ~y2;
      4'd7:    lres = x2 | ~y2;
      4'd8:    lres = ~x2;
      4'd9:    lres = x2;
      default: lres = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_o  <= '0;
      cy_o <= '0;
    end else begin
      p_o  <= (op2 == OP_LOG) ? lres : sum;
      cy_o <= (op2 == OP_LOG) ? '0 : lcy;
    end
  end

  a_r1_reset_zero: assert property (@(posedge clk) !rst_n |=> (p_o == '0 && cy_o == '0));
  a_r2_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (op2 == OP_ACC && !clr2 && !sub2 && y2 == '0) |=> p_o == $past(p_o));
  a_r9_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (op2 == OP_ACC && clr2 && !sub2 && y2 == '0) |=> p_o == '0);
  a_r3_mac_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (op2 == OP_MAC) |=> cy_o[LANES-2:0] == '0);
  a_r7_dual_lane_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (op2 != OP_LOG && op2 != OP_MAC && simd2 == 2'b01) |=> (cy_o[0] == 1'b0 && cy_o[2] == 1'b0));
  a_r10_logic_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (op2 == OP_LOG) |=> cy_o == '0);
endmodule

// File: tb/mac_slice_tb.sv
module mac_slice_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] op_i = '0, simd_i = '0;
  logic sub_i = 1'b0, clr_i = 1'b0;
  logic [3:0] lfn_i = '0;
  logic [24:0] a_i = '0, d_i = '0;
  logic [17:0] b_i = '0;
  logic [47:0] x_i = '0, y_i = '0;
  logic [47:0] p_o;
  logic [3:0] cy_o;
  int checks = 0, fails = 0;
  logic [47:0] exp_p = '0;
  bit done = 0;

  always #10 clk = ~clk;

  mac_slice u_dut (.clk(clk), .rst_n(rst_n), .op_i(op_i), .simd_i(simd_i), .sub_i(sub_i),
    .clr_i(clr_i), .lfn_i(lfn_i), .a_i(a_i), .d_i(d_i), .b_i(b_i), .x_i(x_i), .y_i(y_i),
    .p_o(p_o), .cy_o(cy_o));

  typedef struct packed {
    logic [1:0] op; logic [1:0] simd; logic sub; logic clr; logic [3:0] lf;
    logic [24:0] a; logic [24:0] d; logic [17:0] b; logic [47:0] x; logic [47:0] y;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VT [NV] = '{
    '{2'd0, 2'd0, 1'b0, 1'b1, 4'd0, 25'd3, 25'd4, 18'd5, 48'h0, 48'h0, 4'd3},
    '{2'd0, 2'd0, 1'b0, 1'b0, 4'd0, -25'sd2, 25'd0, 18'd7, 48'h0, 48'h0, 4'd3},
    '{2'd0, 2'd0, 1'b1, 1'b0, 4'd0, 25'd10, -25'sd20, -18'sd3, 48'h0, 48'h0, 4'd3},
    '{2'd0, 2'd0, 1'b0, 1'b1, 4'd0, 25'h0FFFFFF, 25'd1, 18'd2, 48'h0, 48'h0, 4'd4},
    '{2'd0, 2'd0, 1'b0, 1'b1, 4'd0, 25'h1000000, 25'd0, 18'h20000, 48'h0, 48'h0, 4'd3},
    '{2'd0, 2'd2, 1'b0, 1'b0, 4'd0, 25'd1, 25'd1, 18'd1, 48'h0, 48'h0, 4'd3},
    '{2'd1, 2'd0, 1'b0, 1'b0, 4'd0, 25'd0, 25'd0, 18'd0, 48'hFFFF_FFFF_FFFF, 48'h1, 4'd5},
    '{2'd1, 2'd0, 1'b1, 1'b1, 4'd0, 25'd0, 25'd0, 18'd0, 48'h0000_0000_0010, 48'h0000_0000_0020, 4'd5},
    '{2'd1, 2'd1, 1'b0, 1'b0, 4'd0, 25'd0, 25'd0, 18'd0, 48'h000000_FFFFFF, 48'h000000_000001, 4'd6},
    '{2'd1, 2'd2, 1'b0, 1'b0, 4'd0, 25'd0, 25'd0, 18'd0, 48'h7FF_FFF_000_FFF, 48'h001_001_001_001, 4'd6},
    '{2'd1, 2'd3, 1'b1, 1'b0, 4'd0, 25'd0, 25'd0, 18'd0, 48'h005_000_003_010, 48'h001_001_004_010, 4'd7},
    '{2'd1, 2'd1, 1'b1, 1'b0, 4'd0, 25'd0, 25'd0, 18'd0, 48'h000010_000000, 48'h000001_000001, 4'd7},
    '{2'd2, 2'd0, 1'b0, 1'b1, 4'd0, 25'd0, 25'd0, 18'd0, 48'h0, 48'h10, 4'd9},
    '{2'd2, 2'd0, 1'b0, 1'b0, 4'd0, 25'd0, 25'd0, 18'd0, 48'h0, 48'h1, 4'd8},
    '{2'd2, 2'd0, 1'b1, 1'b0, 4'd0, 25'd0, 25'd0, 18'd0, 48'h0, 48'h1, 4'd8},
    '{2'd2, 2'd1, 1'b0, 1'b0, 4'd0, 25'd0, 25'd0, 18'd0, 48'h0, 48'hFFFFFF_FFFFF0, 4'd8},
    '{2'd2, 2'd2, 1'b1, 1'b0, 4'd0, 25'd0, 25'd0, 18'd0, 48'h0, 48'h001_002_003_004, 4'd8},
    '{2'd3, 2'd0, 1'b0, 1'b0, 4'd0, 25'd0, 25'd0, 18'd0, 48'hF0F0_1234_AAAA, 48'hFF00_0F0F_5555, 4'd10},
    '{2'd3, 2'd0, 1'b0, 1'b0, 4'd1, 25'd0, 25'd0, 18'd0, 48'hF0F0_1234_AAAA, 48'hFF00_0F0F_5555, 4'd10},
    '{2'd3, 2'd0, 1'b0, 1'b0, 4'd2, 25'd0, 25'd0, 18'd0, 48'hF0F0_1234_AAAA, 48'hFF00_0F0F_5555, 4'd10},
    '{2'd3, 2'd0, 1'b0, 1'b0, 4'd3, 25'd0, 25'd0, 18'd0, 48'hF0F0_1234_AAAA, 48'hFF00_0F0F_5555, 4'd10},
    '{2'd3, 2'd0, 1'b0, 1'b0, 4'd4, 25'd0, 25'd0, 18'd0, 48'hF0F0_1234_AAAA, 48'hFF00_0F0F_5555, 4'd10},
    '{2'd3, 2'd0, 1'b0, 1'b0, 4'd5, 25'd0, 25'd0, 18'd0, 48'hF0F0_1234_AAAA, 48'hFF00_0F0F_5555, 4'd10},
    '{2'd3, 2'd0, 1'b0, 1'b0, 4'd6, 25'd0, 25'd0, 18'd0, 48'hF0F0_1234_AAAA, 48'hFF00_0F0F_5555, 4'd10},
    '{2'd3, 2'd0, 1'b0, 1'b0, 4'd7, 25'd0, 25'd0, 18'd0, 48'hF0F0_1234_AAAA, 48'hFF00_0F0F_5555, 4'd10},
    '{2'd3, 2'd3, 1'b1, 1'b1, 4'd8, 25'd0, 25'd0, 18'd0, 48'hF0F0_1234_AAAA, 48'hFF00_0F0F_5555, 4'd10},
    '{2'd3, 2'd0, 1'b0, 1'b0, 4'd13, 25'd0, 25'd0, 18'd0, 48'hF0F0_1234_AAAA, 48'hFF00_0F0F_5555, 4'd10}
  };

  function automatic string rname(input logic [3:0] r);
    case (r)
      4'd3: return "R3"; 4'd4: return "R4"; 4'd5: return "R5"; 4'd6: return "R6";
      4'd7: return "R7"; 4'd8: return "R8"; 4'd9: return "R9"; default: return "R10";
    endcase
  endfunction

  function automatic logic [51:0] model(input vec_t t, input logic [47:0] prev);
    logic [24:0] pa;
    logic signed [63:0] pr;
    logic [63:0] uu, vv, ss, mask, u, v, res;
    logic [3:0] cy;
    int w;
    res = '0; cy = '0;
    if (t.op == 2'd3) begin
      case (t.lf)
        4'd0: res = {16'h0, t.x & t.y};
        4'd1: res = {16'h0, t.x | t.y};
        4'd2: res = {16'h0, (t.x | t.y) & ~(t.x & t.y)};
        4'd3: res = {16'h0, ~t.x | ~t.y};
        4'd4: res = {16'h0, ~t.x & ~t.y};
        4'd5: res = {16'h0, (t.x & t.y) | (~t.x & ~t.y)};
        4'd6: res = {16'h0, t.x & ~t.y};
        4'd7: res = {16'h0, ~(~t.x & t.y)};
        4'd8: res = {16'h0, ~t.x};
        4'd9: res = {16'h0, t.x};
        default: res = '0;
      endcase
      return {4'h0, res[47:0]};
    end
    pa = t.a + t.d;
    pr = $signed(pa) * $signed(t.b);
    u = (t.op == 2'd1) ? {16'h0, t.x} : (t.clr ? 64'h0 : {16'h0, prev});
    v = (t.op == 2'd0) ? {16'h0, pr[47:0]} : {16'h0, t.y};
    w = (t.op == 2'd0) ? 48 : t.simd[1] ? 12 : t.simd[0] ? 24 : 48;
    mask = (64'd1 << w) - 64'd1;
    for (int s = 0; s < 48 / w; s++) begin
      uu = (u >> (s * w)) & mask;
      vv = (v >> (s * w)) & mask;
      ss = t.sub ? uu + (~vv & mask) + 64'd1 : uu + vv;
      res = res | ((ss & mask) << (s * w));
      cy[((s + 1) * w) / 12 - 1] = ss[w];
    end
    return {cy, res[47:0]};
  endfunction

  task automatic check(input string tag, input logic [47:0] gp, input logic [47:0] ep,
                       input logic [3:0] gc, input logic [3:0] ec);
    checks++;
    if (gp !== ep || gc !== ec) begin
      fails++;
      $display("FAIL %s: p=%h cy=%b, expected p=%h cy=%b", tag, gp, gc, ep, ec);
    end
  endtask

  task automatic drive(input vec_t t);
    op_i = t.op; simd_i = t.simd; sub_i = t.sub; clr_i = t.clr; lfn_i = t.lf;
    a_i = t.a; d_i = t.d; b_i = t.b; x_i = t.x; y_i = t.y;
  endtask

  task automatic hold();
    op_i = 2'd2; simd_i = 2'd0; sub_i = 1'b0; clr_i = 1'b0; y_i = '0;
  endtask

  task automatic run(input vec_t t);
    logic [51:0] e;
    e = model(t, exp_p);
    drive(t);
    @(posedge clk); @(negedge clk); hold();
    @(posedge clk); @(posedge clk); @(negedge clk);
    check(rname(t.req), p_o, e[47:0], cy_o, e[51:48]);
    exp_p = e[47:0];
  endtask

  function automatic vec_t mac(input logic [24:0] a, input logic [17:0] b, input logic clr);
    return '{2'd0, 2'd0, 1'b0, clr, 4'd0, a, 25'd0, b, 48'h0, 48'h0, 4'd2};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    hold();
    repeat (3) @(negedge clk);
    check("R1 in reset", p_o, 48'h0, cy_o, 4'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", p_o, 48'h0, cy_o, 4'h0);

    for (int i = 0; i < NV; i++) run(VT[i]);

    // hand-computed corner expectations
    run('{2'd1, 2'd2, 1'b0, 1'b0, 4'd0, 25'd0, 25'd0, 18'd0, 48'hFFF_000_FFF_7FF, 48'h001_001_001_001, 4'd6});
    check("R6 hand 4x12", p_o, 48'h000_001_000_800, cy_o, 4'b1010);
    run('{2'd2, 2'd0, 1'b0, 1'b1, 4'd0, 25'd0, 25'd0, 18'd0, 48'h0, 48'h0, 4'd9});
    check("R9 clear to zero", p_o, 48'h0, cy_o, 4'b0000);
    run('{2'd2, 2'd0, 1'b1, 1'b0, 4'd0, 25'd0, 25'd0, 18'd0, 48'h0, 48'h1, 4'd8});
    check("R8 count down through zero", p_o, 48'hFFFF_FFFF_FFFF, cy_o, 4'b0000);
    run('{2'd0, 2'd0, 1'b0, 1'b1, 4'd0, 25'h0FFFFFF, 25'd1, 18'd1, 48'h0, 48'h0, 4'd4});
    check("R4 wrap hand", p_o, 48'hFFFF_FF00_0000, cy_o, 4'b0000);

    // R2: back-to-back issue, exact latency
    run(mac(25'd0, 18'd0, 1'b1));
    drive(mac(25'd2, 18'd3, 1'b1)); @(posedge clk); @(negedge clk);
    drive(mac(25'd5, 18'd1, 1'b0)); @(posedge clk); @(negedge clk);
    check("R2 no early result", p_o, 48'h0, cy_o, 4'h0);
    drive(mac(25'd4, 18'd4, 1'b0)); @(posedge clk); @(negedge clk);
    check("R2 first result", p_o, 48'd6, cy_o, 4'h0);
    drive(mac(-25'sd1, 18'd10, 1'b0)); @(posedge clk); @(negedge clk);
    check("R2 second result", p_o, 48'd11, cy_o, 4'h0);
    hold(); @(posedge clk); @(negedge clk);
    check("R2 third result", p_o, 48'd27, cy_o, 4'h0);
    @(posedge clk); @(negedge clk);
    check("R2 fourth result", p_o, 48'd17, cy_o, 4'h1 << 3);
    @(posedge clk); @(negedge clk);
    check("R2 hold after stream", p_o, 48'd17, cy_o, 4'h0);

    // R1: reset in the middle of a run
    rst_n = 1'b0;
    #1;
    check("R1 mid-run reset", p_o, 48'h0, cy_o, 4'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 stays zero", p_o, 48'h0, cy_o, 4'h0);
    finish_run();
  end
endmodule